// File: doc/BRIEF.md
# Packet-Mode I2C Master Sequencer

This block is an I2C bus master that carries out a whole packet for every accepted write to its command register. One packet may contain a START condition with the 7-bit target address and its read/write bit, one transmitted or received data byte, and a closing STOP condition. Which of these phases run is chosen by individual bits in the command word. Software writes the byte to send into a buffer register, writes the command, then waits for the packet-done flag in the interrupt status register. The received byte and the acknowledge results are read back afterwards. Status flags are cleared by writing ones to them.

The bus side is open drain. The block only ever pulls SCL or SDA low, and it reads the SDA line back through `sda_in`. Bit timing comes from an external tick strobe. Each bit on the wire takes four ticks: one to set up data with SCL low, two with SCL high (data is sampled on the second), and one to pull SCL low again. A multi-byte transfer is built as a chain of packets: the first carries START, the middle ones carry neither START nor STOP, and the last carries STOP.

Top module: `i2c_pkt_master`

## Requirements
- R1: A write to register offset 0 launches a packet only when bit 16 of the written word is 1. The 7-bit target address comes from bits [30:24]. A write with bit 16 clear changes nothing.
- R2: Command bit 0 (START) produces a START condition followed by an address byte. That byte holds the address in its upper seven bits and a R/W bit of 1 when bit 3 (receive) is set, 0 otherwise. When START is absent, the packet continues the open transfer with no address byte. When START is absent and the bus is free, no bus phase runs and only packet-done is raised.
- R3: A command holding only START (plus bit 16) sends START and the address byte with no data byte. The address acknowledge sets status bit 0 (TX-ACK) and a missing acknowledge sets status bit 1 (TX-NAK).
- R4: Command bit 1 sends the low byte of the buffer register (offset 1), most significant bit first. Its acknowledge sets TX-ACK (bit 0) and a NAK sets TX-NAK (bit 1).
- R5: Command bit 3 receives one byte, most significant bit first, and returns it in buffer bits [15:8]. It also sets status bit 2 (RX-done). The master answers ACK, except when bit 4 (last-receive) is set, in which case it answers NAK. When bits 1 and 3 are both set, the receive wins.
- R6: Command bit 5 ends the packet with a STOP condition and sets status bit 4 (normal-stop). This happens even after a NAK.
- R7: A NAK on the address byte skips the data phase of that packet, so the buffer receive byte keeps its old value.
- R8: Every accepted packet ends by setting status bit 16 (packet-done).
- R9: The status register (offset 2) is zero after reset. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: Buffer bit 16 (bus-busy) reads 1 from the end of a START condition until the end of a STOP condition.
- R11: A command written while a packet is in progress is ignored. Reading offset 0 returns bit 16 set while a packet runs.
- R12: After reset, and whenever the bus is free with no packet running, neither SCL nor SDA is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Quarter-bit timing strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 command, 1 buffer, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, registered (one cycle latency) |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
If the phase sequencer is in the wrong state, the fault shows on the bus lines within one tick. It appears as a missing START, a STOP that is absent or early, or a held SCL. It also shows at the status register as a packet-done flag that never rises, or rises with the wrong acknowledge bits. A bit-shift or counter fault shows up on a single packet: the target model receives the wrong byte, the receive byte reads back wrong, or the master answers with the wrong acknowledge. A corrupt busy flag or status store is visible at the next register read.

// File: rtl/i2c_pkt_pkg.sv
package i2c_pkt_pkg;
  // widths of the wire format
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  localparam int REG_AW = 2;

  // command word bit positions
  localparam int CMD_START = 0;
  localparam int CMD_TX    = 1;
  localparam int CMD_RX    = 3;
  localparam int CMD_LAST  = 4;
  localparam int CMD_STOP  = 5;
  localparam int CMD_GO    = 16;
  localparam int CMD_ADDR  = 24;

  // status word bit positions
  localparam int ST_ACK  = 0;
  localparam int ST_NAK  = 1;
  localparam int ST_RXD  = 2;
  localparam int ST_STOP = 4;
  localparam int ST_DONE = 16;

  // buffer word fields
  localparam int BUF_RX   = 8;
  localparam int BUF_BUSY = 16;

  // register offsets
  localparam logic [REG_AW-1:0] OFS_CMD = 2'd0;
  localparam logic [REG_AW-1:0] OFS_BUF = 2'd1;
  localparam logic [REG_AW-1:0] OFS_ST  = 2'd2;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_ADDR, SQ_DATA, SQ_STOP, SQ_DONE
  } sq_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic start;
    logic tx;
    logic rx;
    logic last;
    logic stop;
  } pkt_cmd_t;

  typedef struct packed {
    logic ack;
    logic nak;
    logic rxd;
    logic stp;
    logic done;
  } pkt_evt_t;
endpackage

// File: rtl/i2c_pkt_regs.sv
module i2c_pkt_regs
  import i2c_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              active,
  input  logic              bus_busy,
  input  logic [BYTE_W-1:0] rx_byte,
  input  pkt_evt_t          evt,
  output logic              go,
  output pkt_cmd_t          cmd,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rdata
);
  pkt_evt_t          st_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_cmd, wr_buf, wr_st;

  assign wr_cmd = we && (addr == OFS_CMD);
  assign wr_buf = we && (addr == OFS_BUF);
  assign wr_st  = we && (addr == OFS_ST);

  // command decode straight from the write bus
  assign cmd.addr  = wdata[CMD_ADDR +: ADDR_W];
  assign cmd.start = wdata[CMD_START];
  assign cmd.tx    = wdata[CMD_TX];
  assign cmd.rx    = wdata[CMD_RX];
  assign cmd.last  = wdata[CMD_LAST];
  assign cmd.stop  = wdata[CMD_STOP];
  assign go        = wr_cmd && wdata[CMD_GO] && !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte <= '0;
    end else if (wr_buf) begin
      tx_byte <= wdata[BYTE_W-1:0];
    end
  end

  // write-one-to-clear status; a new event wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      st_q.ack  <= evt.ack  | (st_q.ack  & ~(wr_st & wdata[ST_ACK]));
      st_q.nak  <= evt.nak  | (st_q.nak  & ~(wr_st & wdata[ST_NAK]));
      st_q.rxd  <= evt.rxd  | (st_q.rxd  & ~(wr_st & wdata[ST_RXD]));
      st_q.stp  <= evt.stp  | (st_q.stp  & ~(wr_st & wdata[ST_STOP]));
      st_q.done <= evt.done | (st_q.done & ~(wr_st & wdata[ST_DONE]));
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CMD: rd_mux[CMD_GO] = active;
      OFS_BUF: begin
        rd_mux[BYTE_W-1:0]        = tx_byte;
        rd_mux[BUF_RX +: BYTE_W]  = rx_byte;
        rd_mux[BUF_BUSY]          = bus_busy;
      end
      OFS_ST: begin
        rd_mux[ST_ACK]  = st_q.ack;
        rd_mux[ST_NAK]  = st_q.nak;
        rd_mux[ST_RXD]  = st_q.rxd;
        rd_mux[ST_STOP] = st_q.stp;
        rd_mux[ST_DONE] = st_q.done;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R8
  // done_set_chk
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    evt.done |=> st_q.done);

  // R9
  // ack_hold_chk
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q.ack && !wr_st && !evt.ack) |=> st_q.ack);
endmodule

// File: rtl/i2c_pkt_seq.sv
module i2c_pkt_seq
  import i2c_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              go,
  input  pkt_cmd_t          cmd,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_in,
  output logic              scl_lo,
  output logic              sda_lo,
  output logic              bus_busy,
  output logic              active,
  output logic [BYTE_W-1:0] rx_byte,
  output pkt_evt_t          evt
);
  localparam int IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] ACK_SLOT = IDX_W'(BYTE_W);

  sq_state_e         state;
  pkt_cmd_t          cur;
  logic [1:0]        ph;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] shreg;
  logic              ack_seen;
  logic              rx_dir;
  logic              drv;
  logic              in_byte;

  assign active  = (state != SQ_IDLE);
  assign in_byte = (state == SQ_ADDR) || (state == SQ_DATA);
  assign rx_dir  = (state == SQ_DATA) && cur.rx;

  // level the master pulls onto SDA for the current bit slot
  always_comb begin
    if (idx == ACK_SLOT) drv = rx_dir ? ~cur.last : 1'b0;
    else                 drv = rx_dir ? 1'b0 : ~shreg[BYTE_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cur      <= '0;
      ph       <= '0;
      idx      <= '0;
      shreg    <= '0;
      ack_seen <= 1'b0;
      scl_lo   <= 1'b0;
      sda_lo   <= 1'b0;
      bus_busy <= 1'b0;
      rx_byte  <= '0;
      evt      <= '0;
    end else begin
      evt <= '0;
      case (state)
        SQ_IDLE: begin
          if (go) begin
            cur <= cmd;
            ph  <= '0;
            idx <= '0;
            if (cmd.start) begin
              state <= SQ_START;
            end else if (bus_busy && (cmd.tx || cmd.rx)) begin
              shreg <= tx_byte;
              state <= SQ_DATA;
            end else if (bus_busy && cmd.stop) begin
              state <= SQ_STOP;
            end else begin
              state <= SQ_DONE;
            end
          end
        end

        SQ_START: begin
          if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_lo <= 1'b0;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b1;
              default: begin
                scl_lo   <= 1'b1;
                bus_busy <= 1'b1;
                shreg    <= {cur.addr, cur.rx};
                idx      <= '0;
                state    <= SQ_ADDR;
              end
            endcase
          end
        end

        SQ_ADDR, SQ_DATA: begin
          if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_lo <= drv;
              2'd1: scl_lo <= 1'b0;
              2'd2: begin
                if (idx == ACK_SLOT) ack_seen <= ~sda_in;
                else if (rx_dir)     shreg <= {shreg[BYTE_W-2:0], sda_in};
              end
              default: begin
                scl_lo <= 1'b1;
                if (idx != ACK_SLOT) begin
                  idx <= idx + 1'b1;
                  if (!rx_dir) shreg <= {shreg[BYTE_W-2:0], 1'b0};
                end else if (state == SQ_ADDR) begin
                  evt.ack <= ack_seen;
                  evt.nak <= ~ack_seen;
                  idx     <= '0;
                  if (ack_seen && (cur.tx || cur.rx)) begin
                    shreg <= tx_byte;
                    state <= SQ_DATA;
                  end else begin
                    state <= cur.stop ? SQ_STOP : SQ_DONE;
                  end
                end else begin
                  if (rx_dir) begin
                    rx_byte <= shreg;
                    evt.rxd <= 1'b1;
                  end else begin
                    evt.ack <= ack_seen;
                    evt.nak <= ~ack_seen;
                  end
                  state <= cur.stop ? SQ_STOP : SQ_DONE;
                end
              end
            endcase
          end
        end

        SQ_STOP: begin
          if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_lo <= 1'b1;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b0;
              default: begin
                bus_busy <= 1'b0;
                evt.stp  <= 1'b1;
                state    <= SQ_DONE;
              end
            endcase
          end
        end

        SQ_DONE: begin
          if (scl_lo) sda_lo <= 1'b0;
          evt.done <= 1'b1;
          state    <= SQ_IDLE;
        end

        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R11
  // go_idle_chk
  go_idle_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> (state == SQ_IDLE));

  // R10
  // busy_rise_chk
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> ($past(state) == SQ_START));

  // R6
  // busy_fall_chk
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> evt.stp);

  // R12
  // idle_release_chk
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && !bus_busy) |-> (!scl_lo && !sda_lo));

  // R8
  // evt_excl_chk
  evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    in_byte |-> !evt.done);
endmodule

// File: rtl/i2c_pkt_master.sv
module i2c_pkt_master
  import i2c_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);
  logic              go;
  pkt_cmd_t          cmd;
  logic [BYTE_W-1:0] tx_byte;
  logic [BYTE_W-1:0] rx_byte;
  logic              active;
  logic              bus_busy;
  pkt_evt_t          evt;

  i2c_pkt_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .active   (active),
    .bus_busy (bus_busy),
    .rx_byte  (rx_byte),
    .evt      (evt),
    .go       (go),
    .cmd      (cmd),
    .tx_byte  (tx_byte),
    .rdata    (reg_rdata)
  );

  i2c_pkt_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (bit_tick),
    .go       (go),
    .cmd      (cmd),
    .tx_byte  (tx_byte),
    .sda_in   (sda_in),
    .scl_lo   (scl_drive_low),
    .sda_lo   (sda_drive_low),
    .bus_busy (bus_busy),
    .active   (active),
    .rx_byte  (rx_byte),
    .evt      (evt)
  );
endmodule

// File: tb/i2c_pkt_master_tb_top.sv
`timescale 1ns/1ps
module i2c_pkt_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        scl_drive_low, sda_drive_low;
  logic        slv_pull = 1'b0;
  wire         sda_bus = ~(sda_drive_low | slv_pull);
  wire         scl_bus = ~scl_drive_low;

  int total = 0;
  int bad = 0;
  int scl_low_cnt = 0;

  always #4 clk = ~clk;

  i2c_pkt_master dut_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sda_in(sda_bus), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  // quarter-bit strobe every fourth clock
  int tdiv = 0;
  always @(posedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    bit_tick <= (tdiv == 3);
    if (scl_drive_low) scl_low_cnt <= scl_low_cnt + 1;
  end

  // ---------------- target model ----------------
  localparam logic [6:0] SLV_ADDR = 7'h2C;
  int         bitcnt = 0;
  logic       sel = 0, in_addr = 0, matched = 0, rw = 0;
  logic [7:0] sr = 0, slv_rd = 0, slv_wr_seen = 0;
  logic       slv_ack_wr = 1, mack = 0;

  always @(negedge sda_bus) if (scl_bus) begin
    sel = 1; in_addr = 1; bitcnt = 0; matched = 0; rw = 0;
  end
  always @(posedge sda_bus) if (scl_bus) begin
    sel = 0; slv_pull = 0;
  end
  always @(posedge scl_bus) if (sel) begin
    if (bitcnt < 8) begin
      sr = {sr[6:0], sda_bus}; bitcnt++;
    end else if (bitcnt == 8) begin
      if (!in_addr && rw && matched) begin
        mack = ~sda_bus;
        if (sda_bus) matched = 0;
      end
      bitcnt = 9;
    end
  end
  always @(negedge scl_bus) if (sel) begin
    if (bitcnt == 8) begin
      if (in_addr) begin
        matched = (sr[7:1] == SLV_ADDR); rw = sr[0]; slv_pull = matched;
      end else if (!rw) begin
        slv_wr_seen = sr; slv_pull = matched & slv_ack_wr;
      end else slv_pull = 0;
    end else if (bitcnt == 9) begin
      bitcnt = 0; in_addr = 0; slv_pull = matched & rw & ~slv_rd[7];
    end else if (bitcnt < 8 && !in_addr && rw && matched) begin
      slv_pull = ~slv_rd[7 - bitcnt];
    end else slv_pull = 0;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #1 d = reg_rdata;
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = 0;
    for (int k = 0; k < 3000; k++) begin
      rd(2'd2, st);
      if (st[16]) break;
    end
  endtask

  // cmd, tx, target read byte, target acks writes, exp status, exp rx, exp busy, exp master ack
  localparam int NV = 9;
  localparam logic [75:0] VEC [0:NV-1] = '{
    {32'h2C010021, 8'h00, 8'h00, 1'b1, 17'h10011, 8'h00, 1'b0, 1'b0}, // R3 zero-length ack
    {32'h33010021, 8'h00, 8'h00, 1'b1, 17'h10012, 8'h00, 1'b0, 1'b0}, // R3 R6 address nak
    {32'h2C010023, 8'hA5, 8'h00, 1'b1, 17'h10011, 8'h00, 1'b0, 1'b0}, // R4 write ack
    {32'h2C010003, 8'h5A, 8'h00, 1'b0, 17'h10003, 8'h00, 1'b1, 1'b0}, // R4 data nak, no stop
    {32'h00010020, 8'h00, 8'h00, 1'b1, 17'h10010, 8'h00, 1'b0, 1'b0}, // R6 stop only
    {32'h2C010009, 8'h00, 8'h3C, 1'b1, 17'h10005, 8'h3C, 1'b1, 1'b1}, // R5 read, ack
    {32'h00010038, 8'h00, 8'h3C, 1'b1, 17'h10014, 8'h3C, 1'b0, 1'b0}, // R2 continue, last
    {32'h2C010039, 8'h00, 8'hC3, 1'b1, 17'h10015, 8'hC3, 1'b0, 1'b0}, // R5 single read
    {32'h51010039, 8'h00, 8'hC3, 1'b1, 17'h10012, 8'hC3, 1'b0, 1'b0}  // R7 nak skips data
  };

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] st, bf, c0;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    // reset state
    chk("R12 scl after reset", {31'd0, scl_drive_low}, 0);
    chk("R12 sda after reset", {31'd0, sda_drive_low}, 0);
    rd(2'd2, st); chk("R9 status after reset", st, 0);
    rd(2'd1, bf); chk("R10 busy after reset", {31'd0, bf[16]}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VEC[i];
      slv_rd = v[35:28]; slv_ack_wr = v[27]; slv_wr_seen = 0; mack = 0;
      wr(2'd1, {24'd0, v[43:36]});
      wr(2'd0, v[75:44]);
      wait_done(st);
      chk($sformatf("R8 R4 R5 status vec%0d", i), st, {15'd0, v[26:10]});
      rd(2'd1, bf);
      chk($sformatf("R10 busy vec%0d", i), {31'd0, bf[16]}, {31'd0, v[1]});
      if (v[12]) begin
        chk($sformatf("R5 rx byte vec%0d", i), {24'd0, bf[15:8]}, {24'd0, v[9:2]});
        chk($sformatf("R5 master ack vec%0d", i), {31'd0, mack}, {31'd0, v[0]});
      end
      if (v[26:10] == 17'h10012 && v[47])
        chk($sformatf("R7 rx kept vec%0d", i), {24'd0, bf[15:8]}, {24'd0, v[9:2]});
      if (v[45] && v[10])
        chk($sformatf("R4 byte on bus vec%0d", i), {24'd0, slv_wr_seen}, {24'd0, v[43:36]});
      if (!v[1]) begin
        chk($sformatf("R12 lines free vec%0d", i), {30'd0, scl_drive_low, sda_drive_low}, 0);
      end
      wr(2'd2, 32'h0001_FFFF);
      rd(2'd2, st);
      chk($sformatf("R9 cleared vec%0d", i), st, 0);
    end

    // R9 partial clear and zero write
    wr(2'd0, 32'h2C010021);
    wait_done(st);
    wr(2'd2, 32'h1);
    rd(2'd2, st); chk("R9 clear one bit", st, 32'h10010);
    wr(2'd2, 32'h0);
    rd(2'd2, st); chk("R9 zero write", st, 32'h10010);
    wr(2'd2, 32'h10010);
    rd(2'd2, st); chk("R9 clear rest", st, 0);

    // R11 second command during a packet is dropped
    wr(2'd0, 32'h2C010021);
    wr(2'd0, 32'h33010021);
    rd(2'd0, c0); chk("R11 active flag", {31'd0, c0[16]}, 1);
    wait_done(st);
    chk("R11 ignored command", st, 32'h10011);
    wr(2'd2, 32'h0001_FFFF);

    // R1 no launch without bit 16
    scl_low_cnt = 0;
    wr(2'd0, 32'h2C000021);
    repeat (400) @(negedge clk);
    rd(2'd2, st); chk("R1 no launch status", st, 0);
    chk("R1 no bus activity", scl_low_cnt, 0);

    // R2 continuation on a free bus only completes
    scl_low_cnt = 0;
    wr(2'd0, 32'h2C010002);
    wait_done(st);
    chk("R2 free bus no start", st, 32'h10000);
    chk("R2 no clocks on free bus", scl_low_cnt, 0);
    wr(2'd2, 32'h0001_FFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule